// File: doc/BRIEF.md
# Indirect Slow-Register Bridge

This block gives a 32-bit host port access to a bank of 16-bit configuration registers that are too slow to sit directly on the host bus. The host sees only two words: a command word and a data word. To write an internal register, the host first puts the value in the data word. It then writes the command word with the register index and the write flag set. To read, it writes the command word with the flag clear, waits until the busy bit drops, and then reads the data word.

Each internal access takes a fixed, parameterised number of clocks. While an access is running, the command word shows a busy bit, and any further command write is dropped. The bank also drives a 48-bit station address taken from three consecutive registers.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the command word reads 0x00000000, the data word reads 0x00000000 and `station_addr_o` is all zero.
- R2: A command write accepted while idle sets bit 31 of the command word. Bit 31 reads 1 on exactly LATENCY consecutive clocks after the accepting edge (default 16) and reads 0 from the next clock on.
- R3: When bit 16 of the accepted command word is 1, the access stores the data word's value into the register selected by bits [IDX_W-1:0] (IDX_W = 5 by default) when the access completes.
- R4: When bit 16 is 0, on completion the data word takes the selected register's value in bits [15:0]. Bits [31:16] of the data word always read 0.
- R5: A command write while bit 31 is 1 is ignored. It starts no access, changes neither the index nor the flag fields, does not alter the end time of the running access, and writes no register.
- R6: A host data-word write keeps only bits [15:0]. The data word keeps its value until the host writes it or a read access completes; write accesses leave it unchanged.
- R7: A write access stores the data value that was held when the command was accepted. Data-word writes made while that access is busy do not change the stored value.
- R8: `station_addr_o[47:32]`, `[31:16]` and `[15:0]` show registers STA_BASE, STA_BASE+1 and STA_BASE+2 (default 4). The high byte of each register is the earlier octet.
- R9: The command word reads back bit 31 = busy, bit 16 = last accepted flag, bits [IDX_W-1:0] = last accepted index, and 0 in all other bits. Command-word bits outside these fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_i | input | 1 | Host write strobe qualifier |
| hwrite_i | input | 1 | Host write enable |
| hoff_i | input | 1 | Word select: 0 command word, 1 data word |
| hwdata_i | input | 32 | Host write data |
| hrdata_o | output | 32 | Read data of the word chosen by hoff_i |
| station_addr_o | output | 48 | Station address from three bank registers |

## Verification
A stuck or early-clearing busy flag shows up at the ports as bit 31 of the command word being wrong on the first clock after LATENCY busy clocks. The bench polls that bit every clock, so such an error is caught within one cycle of the expected completion.

A data latch that is too eager or too lazy shows as a wrong data word. The bench reads the data word right after each completion and once during a busy read. A lost or duplicated access shows as wrong contents in a later read-back of the register or in the station address.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  localparam int unsigned HOST_W      = 32;
  localparam int unsigned REG_W       = 16;
  localparam int unsigned WR_FLAG_BIT = 16;
  localparam int unsigned BUSY_BIT    = 31;
  localparam int unsigned STA_REGS    = 3;

  typedef enum logic {
    SEL_CMD  = 1'b0,
    SEL_DATA = 1'b1
  } host_sel_e;
endpackage

// File: rtl/ibr_sequencer.sv
module ibr_sequencer
  import ibr_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic              cmd_wr_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic              done_i,
  output logic              launch_o,
  output logic              busy_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [HOST_W-1:0] cmd_rdata_o
);
  logic             busy_q;
  logic             wr_q;
  logic [IDX_W-1:0] idx_q;

  assign launch_o = cmd_we_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
    end else if (launch_o) begin
      busy_q <= 1'b1;
      wr_q   <= cmd_wr_i;
      idx_q  <= cmd_idx_i;
    end else if (done_i) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    cmd_rdata_o              = '0;
    cmd_rdata_o[IDX_W-1:0]   = idx_q;
    cmd_rdata_o[WR_FLAG_BIT] = wr_q;
    cmd_rdata_o[BUSY_BIT]    = busy_q;
  end

  assign busy_o = busy_q;
  assign wr_o   = wr_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/ibr_slow_bank.sv
module ibr_slow_bank
  import ibr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LATENCY  = 16,
  parameter int unsigned STA_BASE = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        wr_i,
  input  logic [$clog2(NUM_REGS)-1:0] idx_i,
  input  logic [REG_W-1:0]            wdata_i,
  output logic                        done_o,
  output logic [REG_W-1:0]            rdata_o,
  output logic [STA_REGS*REG_W-1:0]   station_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam int unsigned CNT_W = $clog2(LATENCY + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             op_wr_q;
  logic [IDX_W-1:0] op_idx_q;
  logic [REG_W-1:0] op_wdata_q;
  logic [REG_W-1:0] mem_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      op_wr_q    <= 1'b0;
      op_idx_q   <= '0;
      op_wdata_q <= '0;
    end else if (start_i) begin
      active_q   <= 1'b1;
      cnt_q      <= CNT_W'(LATENCY - 1);
      op_wr_q    <= wr_i;
      op_idx_q   <= idx_i;
      op_wdata_q <= wdata_i;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign done_o = active_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (done_o && op_wr_q) begin
      mem_q[op_idx_q] <= op_wdata_q;
    end
  end

  assign rdata_o = mem_q[op_idx_q];

  // earlier octet sits in the high byte, first register at the top
  for (genvar k = 0; k < STA_REGS; k++) begin : g_sta
    assign station_o[(STA_REGS-k)*REG_W-1 -: REG_W] = mem_q[STA_BASE+k];
  end
endmodule

// File: rtl/ibr_host_regs.sv
module ibr_host_regs
  import ibr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  host_sel_e         sel_i,
  input  logic              data_we_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              capture_i,
  input  logic [REG_W-1:0]  capture_data_i,
  input  logic [HOST_W-1:0] cmd_rdata_i,
  output logic [REG_W-1:0]  data_o,
  output logic [HOST_W-1:0] hrdata_o
);
  logic [REG_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (capture_i) data_q <= capture_data_i;
    else if (data_we_i) data_q <= wdata_i;
  end

  assign data_o   = data_q;
  assign hrdata_o = (sel_i == SEL_DATA) ? {{(HOST_W-REG_W){1'b0}}, data_q} : cmd_rdata_i;
endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LATENCY  = 16,
  parameter int unsigned STA_BASE = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        hsel_i,
  input  logic        hwrite_i,
  input  logic        hoff_i,
  input  logic [31:0] hwdata_i,
  output logic [31:0] hrdata_o,
  output logic [47:0] station_addr_o
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  host_sel_e         sel_w;
  logic              cmd_we_w, data_we_w;
  logic              launch_w, busy_w, done_w, op_wr_w;
  logic [IDX_W-1:0]  op_idx_w;
  logic [HOST_W-1:0] cmd_rdata_w;
  logic [REG_W-1:0]  data_w, bank_rdata_w;
  logic              unused_hwdata;

  assign sel_w         = host_sel_e'(hoff_i);
  assign cmd_we_w      = hsel_i & hwrite_i & (sel_w == SEL_CMD);
  assign data_we_w     = hsel_i & hwrite_i & (sel_w == SEL_DATA);
  assign unused_hwdata = ^hwdata_i[31:WR_FLAG_BIT+1];

  ibr_sequencer #(.IDX_W(IDX_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (cmd_we_w),
    .cmd_wr_i    (hwdata_i[WR_FLAG_BIT]),
    .cmd_idx_i   (hwdata_i[IDX_W-1:0]),
    .done_i      (done_w),
    .launch_o    (launch_w),
    .busy_o      (busy_w),
    .wr_o        (op_wr_w),
    .idx_o       (op_idx_w),
    .cmd_rdata_o (cmd_rdata_w)
  );

  ibr_slow_bank #(.NUM_REGS(NUM_REGS), .LATENCY(LATENCY), .STA_BASE(STA_BASE)) i_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (launch_w),
    .wr_i      (hwdata_i[WR_FLAG_BIT]),
    .idx_i     (hwdata_i[IDX_W-1:0]),
    .wdata_i   (data_w),
    .done_o    (done_w),
    .rdata_o   (bank_rdata_w),
    .station_o (station_addr_o)
  );

  ibr_host_regs i_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sel_i          (sel_w),
    .data_we_i      (data_we_w),
    .wdata_i        (hwdata_i[REG_W-1:0]),
    .capture_i      (done_w & ~op_wr_w),
    .capture_data_i (bank_rdata_w),
    .cmd_rdata_i    (cmd_rdata_w),
    .data_o         (data_w),
    .hrdata_o       (hrdata_o)
  );
endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk #(
  parameter int unsigned LATENCY = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hsel_i,
  input logic        hwrite_i,
  input logic        hoff_i,
  input logic [15:0] hrdata_hi_i,
  input logic        busy_i,
  input logic        launch_i,
  input logic        done_i,
  input logic [30:0] cmd_low_i,
  input logic [15:0] data_i
);
  int unsigned chk_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       chk_cnt <= 0;
    else if (launch_i) chk_cnt <= 1;
    else if (busy_i)   chk_cnt <= chk_cnt + 1;
  end

  p_done_at_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (busy_i && chk_cnt == LATENCY));
  p_busy_bounded_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (chk_cnt >= 1 && chk_cnt <= LATENCY));
  p_busy_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_i);
  p_launch_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_i);
  p_ignored_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsel_i && hwrite_i && !hoff_i && busy_i) |=> $stable(cmd_low_i));
  p_data_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !(hsel_i && hwrite_i && hoff_i)) |=> $stable(data_i));
  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hoff_i |-> (hrdata_hi_i == 16'h0));
endmodule

bind ibr_bridge ibr_bridge_chk #(.LATENCY(LATENCY)) i_ibr_bridge_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hsel_i      (hsel_i),
  .hwrite_i    (hwrite_i),
  .hoff_i      (hoff_i),
  .hrdata_hi_i (hrdata_o[31:16]),
  .busy_i      (busy_w),
  .launch_i    (launch_w),
  .done_i      (done_w),
  .cmd_low_i   (cmd_rdata_w[30:0]),
  .data_i      (data_w)
);

// File: tb/test_ibr_bridge.sv
module test_ibr_bridge;
  localparam int LAT  = 16;
  localparam int NREG = 32;
  localparam int STA  = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hsel_i = 1'b0, hwrite_i = 1'b0, hoff_i = 1'b0;
  logic [31:0] hwdata_i = '0;
  logic [31:0] hrdata_o;
  logic [47:0] station_addr_o;

  ibr_bridge #(.NUM_REGS(NREG), .LATENCY(LAT), .STA_BASE(STA)) i_ibr_bridge (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsel_i(hsel_i), .hwrite_i(hwrite_i),
    .hoff_i(hoff_i), .hwdata_i(hwdata_i), .hrdata_o(hrdata_o),
    .station_addr_o(station_addr_o)
  );

  always #10 clk_i = ~clk_i;

  typedef struct {
    int          kind;  // 0 host word, 2 station address
    logic [47:0] exp;
    string       tag;
  } item_t;

  item_t       mon_q[$];
  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;
  logic [15:0] shadow [NREG];
  logic [15:0] data_m;

  initial begin
    forever begin
      @(negedge clk_i);
      #5;
      if (mon_q.size() > 0) begin
        item_t       it;
        logic [47:0] act;
        it  = mon_q.pop_front();
        act = (it.kind == 2) ? station_addr_o : {16'h0, hrdata_o};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] cmd_word(bit busy, bit wr, logic [4:0] idx);
    return {busy, 14'h0, wr, 11'h0, idx};
  endfunction

  task automatic host_wr(bit off, logic [31:0] d);
    @(negedge clk_i);
    hsel_i = 1'b1; hwrite_i = 1'b1; hoff_i = off; hwdata_i = d;
  endtask

  task automatic stage(logic [31:0] d);
    host_wr(1'b1, d);
    data_m = d[15:0];
  endtask

  task automatic expect_rd(bit off, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk_i);
    hsel_i = 1'b0; hwrite_i = 1'b0; hoff_i = off; hwdata_i = '0;
    it.kind = 0; it.exp = {16'h0, e}; it.tag = tag;
    mon_q.push_back(it);
  endtask

  task automatic expect_sta(logic [47:0] e, string tag);
    item_t it;
    @(negedge clk_i);
    hsel_i = 1'b0; hwrite_i = 1'b0; hoff_i = 1'b0; hwdata_i = '0;
    it.kind = 2; it.exp = e; it.tag = tag;
    mon_q.push_back(it);
  endtask

  // inj: 0 none, 1 command write while busy, 2 data write while busy, 3 data check while busy
  task automatic access(logic [31:0] raw, int inj, logic [31:0] inj_val, string tag);
    logic [15:0] staged;
    bit          wr;
    logic [4:0]  idx;
    staged = data_m;
    wr     = raw[16];
    idx    = raw[4:0];
    host_wr(1'b0, raw);
    for (int k = 0; k < LAT; k++) begin
      if (k == 0 && inj == 1) host_wr(1'b0, inj_val);
      else if (k == 0 && inj == 2) stage(inj_val);
      else if (k == 0 && inj == 3) expect_rd(1'b1, {16'h0, data_m}, {tag, " R6 hold while busy"});
      else expect_rd(1'b0, cmd_word(1'b1, wr, idx), {tag, " R2 busy"});
    end
    if (wr) shadow[idx] = staged;
    else    data_m = shadow[idx];
    expect_rd(1'b0, cmd_word(1'b0, wr, idx), {tag, " R2 idle R9 readback"});
    expect_rd(1'b1, {16'h0, data_m}, {tag, " R4 data word"});
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) shadow[i] = 16'h0;
    data_m = 16'h0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    expect_rd(1'b0, 32'h0, "R1 command word");
    expect_rd(1'b1, 32'h0, "R1 data word");
    expect_sta(48'h0, "R1 station");

    stage(32'hABCD_1234);
    expect_rd(1'b1, 32'h0000_1234, "R6 low half kept");

    access(32'h0001_0003, 0, 32'h0, "R3 write");
    stage(32'h0000_5555);
    access(32'h0000_0003, 3, 32'h0, "R4 read");

    stage(32'h0000_0BEE);
    access(32'h0001_0007, 1, 32'h0000_0009, "R5 ignored cmd");
    access(32'h0000_0009, 0, 32'h0, "R5 no stray access");
    access(32'h0000_0007, 0, 32'h0, "R3 readback");

    stage(32'h0000_1111);
    access(32'h0001_0005, 2, 32'h0000_2222, "R7 staged value");
    access(32'h0000_0005, 0, 32'h0, "R7 readback");

    stage(32'h0000_ACDE);
    access(32'h0001_0004, 0, 32'h0, "R8 reg0");
    stage(32'h0000_4800);
    access(32'h0001_0005, 0, 32'h0, "R8 reg1");
    stage(32'h0000_0080);
    access(32'h0001_0006, 0, 32'h0, "R8 reg2");
    expect_sta(48'hACDE_4800_0080, "R8 station octets");

    access(32'hFFFE_FFE2, 0, 32'h0, "R9 index mask");

    repeat (3) @(negedge clk_i);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule